// File: doc/BRIEF.md
# Serial EEPROM Command and Write-Protection Controller

This block is a serial-peripheral slave in front of a 512-byte byte-wide store. It accepts clock modes 0 and 3. Every frame opens with a falling chip select and an 8-bit opcode. Depending on the opcode, an 8-bit address and data bytes follow, all shifted most significant bit first. The ninth address bit is carried inside the opcode. A status byte holds two timer-select bits, two protect-range bits, a write-enable latch and a busy flag.

Writes are staged in a 16-byte page buffer. They reach the store only when chip select is released exactly on a byte boundary. After that, a self-timed cycle of a parameterised number of system clocks runs, and the busy flag stays high for its whole length. The pins SCK, CS_n, SI and WP_n are resynchronised to the system clock, so the serial clock must run well below it (at least six system clocks per serial half period).

Top module: `spi_nvm_guard`

## Requirements
- R1: After reset the status byte reads 30h and so_oe is low. A frame is only honoured after chip select has been seen falling after reset, so bits clocked while chip select was already low at reset have no effect.
- R2: While chip select is high, so_oe is low. SI is taken on rising SCK. SO moves after falling SCK, most significant bit first, so that modes 0 and 3 both read correctly.
- R3: The opcodes are as follows:
  - 06h sets the enable latch.
  - 04h clears the enable latch.
  - 05h reads the status byte, repeated for as long as clocks continue.
  - 01h writes the status byte.
  - 0000_a011 reads the store and 0000_a010 writes it, where opcode bit 3 (a) is address bit 8.
- R4: The status byte is laid out as follows: bits 7..6 read 0, bits 5..4 are the timer-select bits, bits 3..2 are the protect-range bits, bit 1 is the enable latch and bit 0 is the busy flag. A status write changes only bits 5..2, and the new value is visible as soon as its cycle starts.
- R5: The protect range depends on bits 3..2:
  - 00 protects nothing.
  - 01 protects 180h to 1FFh.
  - 10 protects 100h to 1FFh.
  - 11 protects the whole store.

  Data sent to a protected byte is dropped, and the old contents still read back.
- R6: A store or status write needs the enable latch to have been set in an earlier frame. WP_n low clears the latch, keeps it from being set, and cancels a write still being clocked in.
- R7: A write takes effect only when chip select rises right after the last bit of a complete data byte. Rising after a partial byte, or before any data byte, abandons it and leaves the latch unchanged.
- R8: A committed write holds the busy flag at 1 for WR_CYCLES system clocks, then clears both the busy flag and the enable latch. During that time a status read works, and every other command is ignored.
- R9: The low four address bits of a page write wrap within the page, so later bytes overwrite earlier ones. Only bytes actually received are written.
- R10: A store read returns successive bytes, incrementing the address after each one, and wraps from 1FFh to 000h.
- R11: WP_n going low after a write cycle has started does not stop that write from landing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write protect, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; low means high impedance |

## Verification
Two events can land in the same stretch of time: a write protect fall and a self-timed write cycle. They collide both while a write frame is still being clocked in and after the cycle has begun. The bench pulses WP_n low inside an open write frame and expects the busy flag never to rise. It then drops WP_n during a running cycle and expects the busy flag to remain set, the latch to read 0, and the data to land. A status read that arrives during a cycle is the other collision: the bench expects the live busy bit, and expects a competing write in the same window to leave the store untouched.

// File: rtl/spg_pkg.sv
package spg_pkg;
  localparam int ADDR_W    = 9;
  localparam int MEM_DEPTH = 1 << ADDR_W;

  localparam logic [7:0] OP_SET_EN = 8'h06;
  localparam logic [7:0] OP_CLR_EN = 8'h04;
  localparam logic [7:0] OP_RD_ST  = 8'h05;
  localparam logic [7:0] OP_WR_ST  = 8'h01;
  localparam logic [2:0] OP_RD_LO  = 3'b011;
  localparam logic [2:0] OP_WR_LO  = 3'b010;

  typedef enum logic [2:0] {
    PH_OPC, PH_IGNORE, PH_RADDR, PH_WADDR, PH_STDATA, PH_STDONE, PH_WDATA, PH_OUT
  } phase_t;

  // protect range: the top two address bits select the quarter
  function automatic logic prot_hit(input logic [1:0] rng, input logic [ADDR_W-1:0] addr);
    case (rng)
      2'b00:   prot_hit = 1'b0;
      2'b01:   prot_hit = (addr[ADDR_W-1:ADDR_W-2] == 2'b11);
      2'b10:   prot_hit = addr[ADDR_W-1];
      default: prot_hit = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spg_sync.sv
module spg_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/spg_mem.sv
module spg_mem #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/spg_ctrl.sv
module spg_ctrl
  import spg_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              cs_lvl,
  input  logic              si_lvl,
  input  logic              wp_lvl,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              so,
  output logic              so_oe,
  output logic [7:0]        status
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(WR_CYCLES + 1);

  phase_t            phase;
  logic [6:0]        rx_sh;
  logic [2:0]        bit_cnt;
  logic              in_frame, op_a8, arm, complete;
  logic              wel, wip, cyc_page, out_sr;
  logic [1:0]        wd, bl;
  logic [3:0]        nv_new;
  logic [ADDR_W-1:0] w_addr, rd_addr;
  logic [7:0]        pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;
  logic [CW-1:0]     cyc_cnt;
  logic [7:0]        tx_sh;
  logic [2:0]        obit;
  logic              so_q, so_oe_q;

  logic [7:0]        byte_v, sr_val, src;
  logic              byte_end, commit_slot;
  logic [PW-1:0]     cidx;

  assign byte_v      = {rx_sh, si_lvl};
  assign byte_end    = in_frame & sck_rise & (bit_cnt == 3'd7);
  assign sr_val      = {2'b00, wd, bl, wel, wip};
  assign src         = out_sr ? sr_val : mem_rdata;
  assign cidx        = cyc_cnt[PW-1:0];
  assign commit_slot = wip & cyc_page & (cyc_cnt < CW'(PAGE_BYTES));

  assign mem_we    = commit_slot & pvalid[cidx];
  assign mem_waddr = {w_addr[ADDR_W-1:PW], cidx};
  assign mem_wdata = pbuf[cidx];
  assign mem_raddr = rd_addr;
  assign so        = so_q;
  assign so_oe     = so_oe_q;
  assign status    = sr_val;

  // page buffer: data only, no reset needed
  always_ff @(posedge clk) begin
    if (byte_end && phase == PH_WDATA) pbuf[w_addr[PW-1:0]] <= byte_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IGNORE;
      rx_sh    <= '0;
      bit_cnt  <= '0;
      in_frame <= 1'b0;
      op_a8    <= 1'b0;
      arm      <= 1'b0;
      complete <= 1'b0;
      wel      <= 1'b0;
      wip      <= 1'b0;
      cyc_page <= 1'b0;
      out_sr   <= 1'b0;
      wd       <= 2'b11;
      bl       <= 2'b00;
      nv_new   <= '0;
      w_addr   <= '0;
      rd_addr  <= '0;
      pvalid   <= '0;
      cyc_cnt  <= '0;
      tx_sh    <= '0;
      obit     <= '0;
      so_q     <= 1'b0;
      so_oe_q  <= 1'b0;
    end else begin
      so_oe_q <= in_frame & ~cs_lvl;

      if (cs_fall) begin
        in_frame <= 1'b1;
        phase    <= PH_OPC;
        bit_cnt  <= '0;
        complete <= 1'b0;
        arm      <= 1'b0;
        obit     <= '0;
      end

      if (cs_rise) begin
        in_frame <= 1'b0;
        phase    <= PH_IGNORE;
        if (in_frame && complete && arm && wp_lvl && !wip) begin
          wip     <= 1'b1;
          cyc_cnt <= '0;
          if (phase == PH_STDONE) begin
            cyc_page <= 1'b0;
            wd       <= nv_new[3:2];
            bl       <= nv_new[1:0];
          end else begin
            cyc_page <= 1'b1;
          end
        end
      end

      if (in_frame && sck_rise) begin
        rx_sh    <= byte_v[6:0];
        bit_cnt  <= bit_cnt + 3'd1;
        complete <= 1'b0;
        if (bit_cnt == 3'd7) begin
          case (phase)
            PH_OPC: begin
              if (wip && byte_v != OP_RD_ST) begin
                phase <= PH_IGNORE;
              end else if (byte_v == OP_SET_EN) begin
                wel   <= 1'b1;
                phase <= PH_IGNORE;
              end else if (byte_v == OP_CLR_EN) begin
                wel   <= 1'b0;
                phase <= PH_IGNORE;
              end else if (byte_v == OP_RD_ST) begin
                out_sr <= 1'b1;
                phase  <= PH_OUT;
              end else if (byte_v == OP_WR_ST) begin
                arm   <= wel;
                phase <= PH_STDATA;
              end else if (byte_v[7:4] == 4'h0 && byte_v[2:0] == OP_RD_LO) begin
                op_a8 <= byte_v[3];
                phase <= PH_RADDR;
              end else if (byte_v[7:4] == 4'h0 && byte_v[2:0] == OP_WR_LO) begin
                op_a8  <= byte_v[3];
                arm    <= wel;
                pvalid <= '0;
                phase  <= PH_WADDR;
              end else begin
                phase <= PH_IGNORE;
              end
            end
            PH_RADDR: begin
              rd_addr <= {op_a8, byte_v};
              out_sr  <= 1'b0;
              phase   <= PH_OUT;
            end
            PH_WADDR: begin
              w_addr <= {op_a8, byte_v};
              phase  <= PH_WDATA;
            end
            PH_STDATA: begin
              nv_new   <= byte_v[5:2];
              complete <= 1'b1;
              phase    <= PH_STDONE;
            end
            PH_WDATA: begin
              pvalid[w_addr[PW-1:0]] <= ~prot_hit(bl, w_addr);
              w_addr[PW-1:0]         <= w_addr[PW-1:0] + PW'(1);
              complete               <= 1'b1;
            end
            default: ;
          endcase
        end
      end

      if (in_frame && sck_fall && phase == PH_OUT) begin
        if (obit == 3'd0) begin
          so_q  <= src[7];
          tx_sh <= {src[6:0], 1'b0};
          obit  <= 3'd7;
          if (!out_sr) rd_addr <= rd_addr + ADDR_W'(1);
        end else begin
          so_q  <= tx_sh[7];
          tx_sh <= {tx_sh[6:0], 1'b0};
          obit  <= obit - 3'd1;
        end
      end

      if (wip) begin
        cyc_cnt <= cyc_cnt + CW'(1);
        if (cyc_cnt == CW'(WR_CYCLES - 1)) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end
      end

      if (!wp_lvl) begin
        wel <= 1'b0;
        arm <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_nvm_guard.sv
module spi_nvm_guard
  import spg_pkg::*;
#(
  parameter int PAGE_BYTES  = 16,
  parameter int WR_CYCLES   = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  // pin order in the vector: {wp_n, si, cs_n, sck}; cs starts low so a
  // chip select held low through reset never produces a falling edge
  localparam logic [3:0] SYNC_RST = 4'b1000;

  logic [3:0] raw, lvl;
  logic       sck_d, cs_d;
  logic       sck_rise, sck_fall, cs_rise, cs_fall, cs_lvl, si_lvl, wp_lvl;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [7:0]        mem_wdata, mem_rdata;
  logic [7:0]        status;

  assign raw = {wp_n, si, cs_n, sck};

  for (genvar g = 0; g < 4; g++) begin : g_sync
    spg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
      .clk(clk), .rst(rst), .d(raw[g]), .q(lvl[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b0;
    end else begin
      sck_d <= lvl[0];
      cs_d  <= lvl[1];
    end
  end

  assign sck_rise = lvl[0] & ~sck_d;
  assign sck_fall = ~lvl[0] & sck_d;
  assign cs_rise  = lvl[1] & ~cs_d;
  assign cs_fall  = ~lvl[1] & cs_d;
  assign cs_lvl   = lvl[1];
  assign si_lvl   = lvl[2];
  assign wp_lvl   = lvl[3];

  spg_ctrl #(.PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .cs_lvl(cs_lvl), .si_lvl(si_lvl), .wp_lvl(wp_lvl),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_raddr(mem_raddr),
    .so(so), .so_oe(so_oe), .status(status)
  );

  spg_mem #(.DEPTH(MEM_DEPTH), .AW(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/spg_checker.sv
module spg_checker
  import spg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cs_lvl,
  input logic              cs_rise,
  input logic              wp_lvl,
  input logic              so_oe,
  input logic [7:0]        status,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr
);
  AST_RESET_STATUS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> status == 8'h30); // R1

  AST_SO_OFF_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    cs_lvl |=> !so_oe); // R2

  AST_PROTECTED_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !prot_hit(status[3:2], mem_waddr)); // R5

  AST_WP_DROPS_LATCH: assert property (@(posedge clk) disable iff (rst)
    !wp_lvl |=> !status[1]); // R6

  AST_BUSY_FROM_CS_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(status[0]) |-> $past(cs_rise)); // R7

  AST_STORE_WRITE_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> status[0]); // R8
endmodule

bind spi_nvm_guard spg_checker u_spg_checker (
  .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .cs_rise(cs_rise), .wp_lvl(wp_lvl),
  .so_oe(so_oe), .status(status), .mem_we(mem_we), .mem_waddr(mem_waddr)
);

// File: tb/spi_nvm_guard_bench.sv
module spi_nvm_guard_bench;
  localparam int WRC  = 2000;
  localparam int HALF = 8;

  typedef logic [7:0] bq_t[$];
  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, cs_n = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe;
  int   total = 0, bad = 0;
  bit   mode3 = 1'b0;
  exp_t exp_q[$];
  logic [7:0] got_byte;
  event got_ev;

  always #4 clk = ~clk;

  spi_nvm_guard #(.WR_CYCLES(WRC)) u_spi_nvm_guard (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .so(so), .so_oe(so_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each byte the host shifts in
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) begin
        check("scoreboard-empty", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, {24'd0, got_byte}, {24'd0, e.val});
      end
    end
  end

  task automatic hw();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r);
    if (mode3) sck = 1'b0;
    si = b;
    hw();
    r = so;
    sck = 1'b1;
    hw();
    if (!mode3) sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) xbit(b[i], r[i]);
  endtask

  task automatic open_frame();
    sck = mode3;
    hw();
    cs_n = 1'b0;
    hw();
  endtask

  task automatic close_frame();
    hw();
    cs_n = 1'b1;
    hw();
    hw();
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    open_frame();
    xbyte(op, r);
    close_frame();
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_t e;
    logic [7:0] r;
    e.val = v;
    e.tag = tag;
    exp_q.push_back(e);
    xbyte(8'h00, r);
    got_byte = r;
    ->got_ev;
  endtask

  task automatic rd_status(input logic [7:0] v, input string tag);
    logic [7:0] r;
    open_frame();
    xbyte(8'h05, r);
    expect_byte(v, tag);
    close_frame();
  endtask

  task automatic rd_store(input logic [8:0] a, input bq_t vals, input string tag);
    logic [7:0] r;
    open_frame();
    xbyte({4'h0, a[8], 3'b011}, r);
    xbyte(a[7:0], r);
    foreach (vals[i]) expect_byte(vals[i], tag);
    close_frame();
  endtask

  task automatic wr_store(input logic [8:0] a, input bq_t d, input int extra);
    logic [7:0] r;
    logic       rb;
    open_frame();
    xbyte({4'h0, a[8], 3'b010}, r);
    xbyte(a[7:0], r);
    foreach (d[i]) xbyte(d[i], r);
    for (int k = 0; k < extra; k++) xbit(1'b1, rb);
    close_frame();
  endtask

  task automatic wr_status(input logic [7:0] v);
    logic [7:0] r;
    open_frame();
    xbyte(8'h01, r);
    xbyte(v, r);
    close_frame();
  endtask

  task automatic wait_done();
    repeat (WRC + 40) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bq_t q;
    logic [7:0] r;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 so_oe after reset", {31'd0, so_oe}, 32'd0);
    // chip select was low through reset: these bits must be ignored
    xbyte(8'h06, r);
    cs_n = 1'b1;
    hw();
    hw();
    rd_status(8'h30, "R1 status default, no frame before cs fall");

    // output enable follows chip select
    open_frame();
    check("R2 so_oe in frame", {31'd0, so_oe}, 32'd1);
    close_frame();
    check("R2 so_oe deselected", {31'd0, so_oe}, 32'd0);

    cmd(8'h06);
    rd_status(8'h32, "R3 set latch");
    cmd(8'h04);
    rd_status(8'h30, "R3 clear latch");

    // page wrap: 18 bytes from 000h
    cmd(8'h06);
    q = {};
    for (int i = 0; i < 18; i++) q.push_back(8'(8'h40 + i));
    wr_store(9'h000, q, 0);
    rd_status(8'h33, "R8 busy and latch during cycle");
    wait_done();
    rd_status(8'h30, "R8 latch cleared after cycle");
    q = {8'h50, 8'h51};
    for (int i = 2; i < 16; i++) q.push_back(8'(8'h40 + i));
    rd_store(9'h000, q, "R9 page wrap / R10 increment");

    // partial page: only received bytes change
    cmd(8'h06);
    wr_store(9'h005, '{8'hC5, 8'hC6}, 0);
    wait_done();
    rd_store(9'h004, '{8'h44, 8'hC5, 8'hC6, 8'h47}, "R9 only received bytes");

    // no latch from an earlier frame
    wr_store(9'h005, '{8'h11}, 0);
    rd_status(8'h30, "R6 write without latch ignored");
    rd_store(9'h005, '{8'hC5}, "R6 store unchanged");

    // upper half via opcode bit 3, and rollover
    cmd(8'h06);
    q = {};
    for (int i = 0; i < 16; i++) q.push_back(8'(8'h80 + i));
    wr_store(9'h1F0, q, 0);
    wait_done();
    rd_store(9'h1FE, '{8'h8E, 8'h8F, 8'h50, 8'h51}, "R10 rollover / R3 a8");

    // abandoned writes
    cmd(8'h06);
    wr_store(9'h020, '{8'h77}, 3);
    rd_status(8'h32, "R7 partial byte abandons");
    wr_store(9'h021, '{}, 0);
    rd_status(8'h32, "R7 no data byte abandons");
    wr_store(9'h020, '{8'h99}, 0);
    rd_status(8'h33, "R7 byte boundary commits");
    wait_done();
    rd_store(9'h020, '{8'h99}, "R7 committed data");

    // cycle length
    cmd(8'h06);
    wr_store(9'h022, '{8'h5E}, 0);
    repeat (1500) @(negedge clk);
    rd_status(8'h33, "R8 still busy late in cycle");
    repeat (400) @(negedge clk);
    rd_status(8'h30, "R8 idle after cycle");

    // busy ignores other commands
    cmd(8'h06);
    wr_store(9'h030, '{8'h12}, 0);
    rd_status(8'h33, "R8 status readable while busy");
    wr_store(9'h030, '{8'h34}, 0);
    wait_done();
    rd_store(9'h030, '{8'h12}, "R8 write during busy ignored");

    // status write
    cmd(8'h06);
    wr_status(8'hFF);
    rd_status(8'h3F, "R4 new bits visible at cycle start");
    wait_done();
    rd_status(8'h3C, "R4 only bits 5..2 written");
    cmd(8'h06);
    wr_status(8'h04);
    wait_done();
    rd_status(8'h04, "R4 range 01");

    // protection ranges
    cmd(8'h06);
    wr_store(9'h1F0, '{8'h11, 8'h22}, 0);
    wait_done();
    rd_store(9'h1F0, '{8'h80, 8'h81}, "R5 range 01 top quarter kept");
    cmd(8'h06);
    wr_store(9'h100, '{8'h5A}, 0);
    wait_done();
    rd_store(9'h100, '{8'h5A}, "R5 range 01 allows 100h");
    cmd(8'h06);
    wr_status(8'h08);
    wait_done();
    cmd(8'h06);
    wr_store(9'h100, '{8'h6B}, 0);
    wait_done();
    rd_store(9'h100, '{8'h5A}, "R5 range 10 protects 100h");
    cmd(8'h06);
    wr_status(8'h0C);
    wait_done();
    cmd(8'h06);
    wr_store(9'h000, '{8'hEE}, 0);
    wait_done();
    rd_store(9'h000, '{8'h50}, "R5 range 11 protects all");
    cmd(8'h06);
    wr_status(8'h30);
    wait_done();
    rd_status(8'h30, "R4 restored");

    // write protect during a running cycle
    cmd(8'h06);
    wr_store(9'h040, '{8'h3C}, 0);
    wp_n = 1'b0;
    repeat (20) @(negedge clk);
    rd_status(8'h31, "R11 busy kept, latch dropped by wp");
    wp_n = 1'b1;
    wait_done();
    rd_store(9'h040, '{8'h3C}, "R11 data landed");

    // write protect pulse inside an open write frame
    cmd(8'h06);
    open_frame();
    xbyte(8'h02, r);
    xbyte(8'h50, r);
    xbyte(8'h55, r);
    wp_n = 1'b0;
    hw();
    wp_n = 1'b1;
    hw();
    close_frame();
    rd_status(8'h30, "R6 wp aborts pending write");

    // latch cannot be set while protected
    wp_n = 1'b0;
    cmd(8'h06);
    wp_n = 1'b1;
    hw();
    rd_status(8'h30, "R6 wp blocks set latch");

    // clock mode 3
    mode3 = 1'b1;
    rd_store(9'h1FE, '{8'h8E, 8'h8F}, "R2 mode 3 read");
    rd_status(8'h30, "R2 mode 3 status");
    mode3 = 1'b0;
    sck = 1'b0;
    hw();

    check("scoreboard drained", exp_q.size(), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule